// File: doc/BRIEF.md
# Receive-Channel Interrupt Event and Enable Bank

This block gathers completion notices from four receive channels into a small bank of interrupt state that software can inspect and acknowledge. Each channel owns one event bit and one enable bit. A channel's completion input is synchronized to the register clock, and only its rising edge latches the event bit. Software can also force an event on.

Both the event bits and the enable bits are reached through a pair of word offsets. Writing a 1 at the "post" offset sets a bit. Writing a 1 at the "acknowledge" offset clears it. Writing a 0 leaves a bit unchanged.

A single registered summary line rises whenever any pending event has its enable bit set. It is meant to feed one bit of a higher-level interrupt register. Software that sees the summary reads this bank to find which channels need service.

Top module: `irq_bank_top`

## Requirements
- R1: Channel n (n = 0..3) maps to bit n of both the event and the enable registers. Read data bits 31..4 are always 0, and write data bits 31..4 have no effect.
- R2: Each channel input passes through a two-flop synchronizer and then a registered copy. A 0-to-1 change sampled at clock edge k sets the event bit at edge k+2. A level that stays high does not set the bit again.
- R3: Writing to offset 0xA0 sets every event bit whose write-data bit is 1. Write-data bits that are 0 leave their event bits unchanged.
- R4: An event bit clears only when software writes a 1 to that bit at offset 0xA4. An input held high after the clear does not set the bit again until a new rising edge occurs.
- R5: A read at offset 0xA0 returns the raw event bits. A read at offset 0xA4 returns the event bits ANDed with the enable bits.
- R6: Writing a 1 at offset 0xA8 sets an enable bit, and writing a 1 at offset 0xAC clears it. A read at either of these offsets returns the enable bits.
- R7: irq_out is 1 exactly one cycle after the state in which some event bit and its enable bit are both 1.
- R8: If a hardware rising edge and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R9: While rst is high, all event bits, enable bits, irq_out, rd_valid and rd_data are 0.
- R10: Reads at any offset other than 0xA0, 0xA4, 0xA8 and 0xAC return 0. Writes to those other offsets change nothing.
- R11: rd_valid is 1 exactly in the cycle after a cycle with rd_en high, and rd_data then holds the word selected in the rd_en cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the word being accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Marks rd_data valid, one cycle after rd_en |
| chan_done | input | 4 | Per-channel completion level, asynchronous |
| irq_out | output | 1 | Summary interrupt toward the parent register |

## Verification
The bench checks that a completion input held high sets its event bit once and only once. A design that sets on level instead of on edge would fail this by re-setting the bit immediately after software clears it.

It also lines up a rising edge with an acknowledge write to the same bit in the same cycle. A design that lets the clear win would lose that event.

The masked read at the acknowledge offset is compared against the raw read at the post offset. This catches a design that swaps the two views or ignores the enable bits.

Writes that carry zeros, high-order bits, or an unmapped offset are each followed by read-backs. These show whether a faulty decoder cleared or set bits it should have left alone.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  // Byte offsets decoded by software drivers; the set/clear pairing is behaviour.
  localparam logic [7:0] OFS_EV_POST = 8'hA0;
  localparam logic [7:0] OFS_EV_ACK  = 8'hA4;
  localparam logic [7:0] OFS_EN_POST = 8'hA8;
  localparam logic [7:0] OFS_EN_ACK  = 8'hAC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EV_POST,
    SEL_EV_ACK,
    SEL_EN_POST,
    SEL_EN_ACK
  } reg_sel_e;
endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] rise
);
  logic [NCH-1:0] stg [STAGES];
  logic [NCH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign rise = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqb_decode.sv
module irqb_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              [ADDR_W-1:0] addr,
  output irqb_pkg::reg_sel_e             sel
);
  import irqb_pkg::*;

  always_comb begin
    if (addr == ADDR_W'(OFS_EV_POST))      sel = SEL_EV_POST;
    else if (addr == ADDR_W'(OFS_EV_ACK))  sel = SEL_EV_ACK;
    else if (addr == ADDR_W'(OFS_EN_POST)) sel = SEL_EN_POST;
    else if (addr == ADDR_W'(OFS_EN_ACK))  sel = SEL_EN_ACK;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/irqb_regs.sv
module irqb_regs #(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  irqb_pkg::reg_sel_e sel,
  input  logic [NCH-1:0]     wbits,
  input  logic [NCH-1:0]     rise,
  output logic [NCH-1:0]     ev_q,
  output logic [NCH-1:0]     en_q
);
  import irqb_pkg::*;

  logic [NCH-1:0] ev_set, ev_clr, en_set, en_clr;

  always_comb begin
    ev_set = rise;
    ev_clr = '0;
    en_set = '0;
    en_clr = '0;
    if (wr_en) begin
      unique case (sel)
        SEL_EV_POST: ev_set = rise | wbits;
        SEL_EV_ACK:  ev_clr = wbits;
        SEL_EN_POST: en_set = wbits;
        SEL_EN_ACK:  en_clr = wbits;
        default: ;
      endcase
    end
  end

  // Set is applied after clear, so a coincident edge is never lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      en_q <= (en_q & ~en_clr) | en_set;
    end
  end
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top #(
  parameter int NCH         = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [NCH-1:0]    chan_done,
  output logic              irq_out
);
  import irqb_pkg::*;

  reg_sel_e       sel;
  logic [NCH-1:0] rise_w;
  logic [NCH-1:0] ev_q;
  logic [NCH-1:0] en_q;
  logic [DATA_W-1:0] rd_word;
  logic           unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:NCH];

  irqb_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (chan_done),
    .rise(rise_w)
  );

  irqb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr),
    .sel (sel)
  );

  irqb_regs #(.NCH(NCH)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr_en),
    .sel  (sel),
    .wbits(wr_data[NCH-1:0]),
    .rise (rise_w),
    .ev_q (ev_q),
    .en_q (en_q)
  );

  always_comb begin
    unique case (sel)
      SEL_EV_POST:            rd_word = DATA_W'(ev_q);
      SEL_EV_ACK:             rd_word = DATA_W'(ev_q & en_q);
      SEL_EN_POST, SEL_EN_ACK: rd_word = DATA_W'(en_q);
      default:                rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
      irq_out  <= |(ev_q & en_q);
    end
  end
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NCH-1:0]    wbits,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              irq_out,
  input logic [NCH-1:0]    rise_w,
  input logic [NCH-1:0]    ev_q,
  input logic [NCH-1:0]    en_q
);
  logic [NCH-1:0] ack_bits;
  assign ack_bits = (wr_en && addr == ADDR_W'(irqb_pkg::OFS_EV_ACK)) ? wbits : '0;

  // R11
  p_rdvalid_follows_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rdvalid_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R1
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[DATA_W-1:NCH] == '0));
  // R2, R8: a detected edge always leaves its bit set
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_w != '0) |=> ((ev_q & $past(rise_w)) == $past(rise_w)));
  // R4: a bit only falls when an acknowledge write named it
  p_clear_only_ack_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ev_q) & ~ev_q & ~$past(ack_bits)) == '0));
  // R7
  p_summary_r7: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & en_q) != '0) |=> irq_out);
  p_summary_low_r7: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & en_q) == '0) |=> !irq_out);
endmodule

bind irq_bank_top irqb_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wbits   (wr_data[NCH-1:0]),
  .rd_data (rd_data),
  .rd_valid(rd_valid),
  .irq_out (irq_out),
  .rise_w  (rise_w),
  .ev_q    (ev_q),
  .en_q    (en_q)
);

// File: tb/sim_irq_bank_top.sv
`timescale 1ns/1ps
module sim_irq_bank_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  chan_done = '0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_bank_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .chan_done(chan_done), .irq_out(irq_out)
  );

  // {is_read, offset, write data, expected read}
  localparam logic [72:0] VEC [0:15] = '{
    {1'b0, 8'hA8, 32'h0000000F, 32'h0},          // R6 enable all
    {1'b1, 8'hA8, 32'h0,        32'h0000000F},   // R6
    {1'b0, 8'hAC, 32'h00000005, 32'h0},          // R6 disable 0,2
    {1'b1, 8'hAC, 32'h0,        32'h0000000A},   // R6 read via clear offset
    {1'b0, 8'hA0, 32'hFFFFFFF3, 32'h0},          // R3, R1 upper bits ignored
    {1'b1, 8'hA0, 32'h0,        32'h00000003},   // R5 raw
    {1'b1, 8'hA4, 32'h0,        32'h00000002},   // R5 masked
    {1'b0, 8'hA0, 32'h00000000, 32'h0},          // R3 zeros do nothing
    {1'b1, 8'hA0, 32'h0,        32'h00000003},   // R3
    {1'b0, 8'hA4, 32'h00000001, 32'h0},          // R4 ack bit 0
    {1'b1, 8'hA0, 32'h0,        32'h00000002},   // R4
    {1'b1, 8'h10, 32'h0,        32'h00000000},   // R10 unmapped read
    {1'b0, 8'hB0, 32'h0000000F, 32'h0},          // R10 unmapped write
    {1'b0, 8'h00, 32'h0000000D, 32'h0},          // R10 unmapped write
    {1'b1, 8'hA0, 32'h0,        32'h00000002},   // R10
    {1'b1, 8'hA8, 32'h0,        32'h0000000A}    // R10
  };

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
    chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        report();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 irq_out in reset", {31'b0, irq_out}, 32'd0);
    chk("R9 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
    chk("R9 rd_data in reset", rd_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 no rd_valid when idle", {31'b0, rd_valid}, 32'd0);
    do_read(8'hA0, 32'h0, "R9 events zero");
    do_read(8'hA8, 32'h0, "R9 enables zero");

    // table walk
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][72]) do_read(VEC[i][71:64], VEC[i][31:0], $sformatf("table[%0d]", i));
      else            do_write(VEC[i][71:64], VEC[i][63:32]);
    end

    // R7: events 0x2, enables 0xA -> summary high
    @(negedge clk);
    chk("R7 summary on", {31'b0, irq_out}, 32'd1);
    do_write(8'hAC, 32'h2);
    @(negedge clk);
    chk("R7 summary off after disable", {31'b0, irq_out}, 32'd0);
    do_write(8'hA4, 32'hF);
    do_read(8'hA0, 32'h0, "R4 ack all");

    // R2 rising edge on channel 2, with latency
    chan_done[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    do_read(8'hA0, 32'h0, "R2 not yet set after two edges");
    do_read(8'hA0, 32'h4, "R2 edge sets bit 2");
    // R4 held level does not re-set
    do_write(8'hA4, 32'h4);
    repeat (4) @(negedge clk);
    do_read(8'hA0, 32'h0, "R4 held level stays cleared");
    chan_done[2] = 1'b0;
    repeat (4) @(negedge clk);
    chan_done[2] = 1'b1;
    repeat (4) @(negedge clk);
    do_read(8'hA0, 32'h4, "R2 new edge sets again");
    chan_done[2] = 1'b0;
    do_write(8'hA4, 32'h4);

    // R8 edge and acknowledge in the same cycle
    chan_done[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    do_write(8'hA4, 32'h1);
    do_read(8'hA0, 32'h1, "R8 set wins");
    do_write(8'hA4, 32'h1);
    do_read(8'hA0, 32'h0, "R8 later ack clears");
    chan_done[0] = 1'b0;

    // R7 with hardware event and mask
    do_write(8'hA8, 32'h8);
    chan_done[3] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 summary from channel 3", {31'b0, irq_out}, 32'd1);
    do_read(8'hA4, 32'h8, "R5 masked view");

    // R9 reset clears state mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R9 summary cleared", {31'b0, irq_out}, 32'd0);
    rst = 1'b0;
    chan_done = '0;
    do_read(8'hA0, 32'h0, "R9 events cleared");
    do_read(8'hA8, 32'h0, "R9 enables cleared");
    report();
  end
endmodule